// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte standard header of a type-0 PCI configuration space. The header sits inside a 256-byte offset range. A host-side config port issues one access per cycle. Each access carries a byte offset, a size of 1, 2 or 4 bytes, a write flag and write data. Write data is aligned to the least significant bit of the data word, and so is read data. Parameters set the identification fields and the reset values of the six base address registers (BARs). Parameters also set each BAR's aperture size and whether each BAR is a fixed legacy-I/O window.

The block applies the write rules of each register. It supports BAR size discovery by all-ones writes, and it keeps the I/O or memory type bits of each BAR. It handles the expansion-ROM probe value. It drives a decoded base and a size for every BAR. When a BAR moves to a new non-zero address, it pulses `range_chg` for one cycle so that the address decoders downstream can update. Every access returns a response after a fixed number of cycles. The response carries the read data and an error flag.

Register layout, in little-endian byte order:

| Offset | Contents |
|---|---|
| 0x00 | vendor ID |
| 0x02 | device ID |
| 0x04 | command |
| 0x06 | status |
| 0x08 | revision |
| 0x09 to 0x0B | class code |
| 0x0C | cache line size |
| 0x0D | latency timer |
| 0x0E | header type (0) |
| 0x0F | self-test (0) |
| 0x10 to 0x27 | BAR0 to BAR5 |
| 0x28 | card information pointer (0) |
| 0x2C | subsystem vendor ID |
| 0x2E | subsystem ID |
| 0x30 | expansion ROM |
| 0x34 to 0x3B | zero |
| 0x3C | interrupt line |
| 0x3D | interrupt pin |
| 0x3E | minimum grant |
| 0x3F | maximum latency |

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, each identification field reads at its offset in the layout table with its parameter value. A read assembles consecutive bytes little-endian from the offset, zero-extended to 32 bits. The cache line size and latency timer reset to 0. `rsp_valid` and `range_chg` are 0 after reset. Each BAR base output is 0, except that a legacy BAR outputs its reset value.
- R2: A 32-bit write of 0xFFFFFFFF to a non-legacy BAR stores ~(size-1) in the address bits and leaves the type bits unchanged. A size of 0 therefore reads back as only the type bits. A probe write never pulses `range_chg` and never changes the BAR's base output.
- R3: Any other 32-bit BAR write keeps the type bits of the old value and takes only the address bits from the write data. When bit 0 of the old value is 1, the BAR is I/O and the type bits are [1:0]. Otherwise the BAR is memory and the type bits are [3:0].
- R4: A non-probe BAR write with a non-zero address part loads that address part into the BAR's base output. It also drives `range_chg` high for exactly the one cycle after the request's clock edge. A write with a zero address part leaves the base output unchanged and does not pulse `range_chg`.
- R5: A legacy BAR always reads as 0 and ignores writes, including probe writes. Its base output stays at its reset value, and writing it never pulses `range_chg`.
- R6: A 32-bit write of 0xFFFFFFFE to offset 0x30 stores 0xFFFFFFFF. Any other 32-bit value written there is stored unchanged.
- R7: Byte writes update only offsets 0x0C, 0x0D and 0x3C. Byte writes to 0x08, 0x09, 0x0A, 0x0B, 0x3D, 0x3E and 0x3F are ignored without error. A byte write to any other offset is an error.
- R8: Certain accesses are errors: an offset of 0x40 or above, a size other than 1, 2 or 4, a 2-byte access at an odd offset, a 4-byte access at an offset that is not a multiple of 4, and any case named as an error in R7 or R10. An error response returns data 0 and changes no register.
- R9: A 32-bit write at 0x04 stores its low 16 bits into the command register and leaves the status register unchanged. A 32-bit write at any offset below 0x40 other than 0x04, a BAR or 0x30 is discarded without error.
- R10: A 16-bit write at 0x04 or 0x06 stores all 16 bits. A 16-bit write at 0x0C stores only its low byte, into the cache line size, and leaves the latency timer unchanged. A 16-bit write at any other offset is an error.
- R11: The block samples a request on a rising edge. Counting that edge as the first, `rsp_valid` is high for one cycle after the RSP_LAT-th edge. Read data reflects the register state before the request's own write.
- R12: `bar_size` carries each BAR's size parameter. Each size must be 0 or a power of two, and any other value stops elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request, one per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | 8 | Byte offset into config space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4) |
| req_wdata | input | 32 | Write data, aligned to the least significant bit |
| rsp_valid | output | 1 | Response strobe, RSP_LAT cycles after the request |
| rsp_rdata | output | 32 | Read data, aligned to the least significant bit, 0 on error |
| rsp_err | output | 1 | Access was rejected |
| bar_base | output | 6*32 | Decoded base of each BAR; BAR i in bits [32i+31:32i] |
| bar_size | output | 6*32 | Aperture size of each BAR, same packing |
| range_chg | output | 1 | One-cycle pulse when any BAR is relocated |

## Verification
A register write takes effect on the request's own clock edge. Any register change is therefore visible to a read issued in the next cycle. `range_chg` is high only in the cycle just after that edge. The response to every access appears only after the RSP_LAT-th edge, with RSP_LAT set to 2 in the bench.

The bench drives requests on falling edges and samples `range_chg` at the falling edge just after the request edge. It checks again one cycle later that the pulse is gone. It samples the response at the falling edge after the second edge. A dedicated scenario confirms that `rsp_valid` is low one cycle early and one cycle late. Base outputs are compared right after the response of the write that moved them.

// File: rtl/cfg_pkg.sv
// cfg_pkg: shared constants for the configuration header register file.
// Assumes a fixed type-0 layout; offsets below are decoded by software and
// therefore fixed by behaviour, not tunable.
package cfg_pkg;
    localparam int NUM_BARS  = 6;
    localparam int WORD_W    = 32;
    localparam int WORDS     = 16;          // 64-byte standard header
    localparam logic [7:0] HDR_END   = 8'h40;
    localparam logic [7:0] OFF_CMD   = 8'h04;
    localparam logic [7:0] OFF_STS   = 8'h06;
    localparam logic [7:0] OFF_REV   = 8'h08;
    localparam logic [7:0] OFF_CLS   = 8'h0C;
    localparam logic [7:0] OFF_LAT   = 8'h0D;
    localparam logic [7:0] OFF_BAR0  = 8'h10;
    localparam logic [7:0] OFF_ROM   = 8'h30;
    localparam logic [7:0] OFF_INTL  = 8'h3C;
    localparam logic [7:0] OFF_INTP  = 8'h3D;
    localparam logic [31:0] IO_KEEP  = 32'h0000_0003;
    localparam logic [31:0] MEM_KEEP = 32'h0000_000F;
    localparam logic [31:0] ALL_ONES = 32'hFFFF_FFFF;
    localparam logic [31:0] ROM_PROBE = 32'hFFFF_FFFE;

    // True when a size is zero or a power of two.
    function automatic bit size_legal(input logic [31:0] sz);
        return (sz == 32'd0) || ((sz & (sz - 32'd1)) == 32'd0);
    endfunction
endpackage

// File: rtl/cfg_bar_slot.sv
// cfg_bar_slot: one base address register with probe handling, type-bit
// preservation and decoded base. Assumes wr_en is a qualified, error-free
// 32-bit write aimed at this BAR. A legacy slot is read-as-zero and fixed.
module cfg_bar_slot
    import cfg_pkg::*;
#(
    parameter logic [31:0] INIT   = 32'h0,
    parameter logic [31:0] SIZE   = 32'h0,
    parameter bit          LEGACY = 1'b0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [31:0] wdata,
    output logic [31:0] rd_val,
    output logic [31:0] base_o,
    output logic        reloc_o
);
    localparam logic [31:0] SZ_M1 = SIZE - 32'd1;

    if (!size_legal(SIZE)) begin : g_bad_size
        $error("cfg_bar_slot: SIZE must be zero or a power of two");
    end

    if (LEGACY) begin : g_legacy
        logic unused_inputs;
        // Fixed window: inputs are intentionally ignored.
        assign unused_inputs = ^{wr_en, wdata};
        assign rd_val  = '0;
        assign base_o  = INIT;
        assign reloc_o = 1'b0;
    end else begin : g_normal
        logic [31:0] bar_q, base_q, keep, addr_new, bar_nxt;
        logic        reloc_q, probe, moves;

        // Next-value computation for a write to this BAR.
        always_comb begin
            keep     = bar_q[0] ? IO_KEEP : MEM_KEEP;
            probe    = (wdata == ALL_ONES);
            addr_new = probe ? ~SZ_M1 : (wdata & ~keep);
            bar_nxt  = (addr_new & ~keep) | (bar_q & keep);
            moves    = !probe && (addr_new != 32'd0);
        end

        // State update: register value, decoded base and relocation pulse.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                bar_q   <= INIT;
                base_q  <= '0;
                reloc_q <= 1'b0;
            end else begin
                reloc_q <= wr_en && moves;
                if (wr_en) bar_q <= bar_nxt;
                if (wr_en && moves) base_q <= addr_new;
            end
        end

        assign rd_val  = bar_q;
        assign base_o  = base_q;
        assign reloc_o = reloc_q;

        // R3: type bits never change after reset
        assert_type_kept_R3: assert property (@(posedge clk) disable iff (!rst_n)
            $stable(bar_q[0]) && (bar_q[0] ? $stable(bar_q[1:0]) : $stable(bar_q[3:0])));

        // R4: a relocation pulse always comes with a non-zero base
        assert_reloc_base_R4: assert property (@(posedge clk) disable iff (!rst_n)
            reloc_q |-> (base_q != 32'd0));
    end
endmodule

// File: rtl/cfg_rsp_pipe.sv
// cfg_rsp_pipe: fixed-latency delay line for the access response.
// Assumes LAT >= 1; accepts a new entry every cycle.
module cfg_rsp_pipe #(
    parameter int LAT = 1,
    parameter int W   = 33
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    logic         v_q [LAT];
    logic [W-1:0] d_q [LAT];

    for (genvar s = 0; s < LAT; s++) begin : g_stage
        // Stage s: loads from the input (s == 0) or the previous stage.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q[s] <= 1'b0;
                d_q[s] <= '0;
            end else if (s == 0) begin
                v_q[s] <= in_valid;
                d_q[s] <= in_data;
            end else begin
                v_q[s] <= v_q[(s > 0) ? s - 1 : 0];
                d_q[s] <= d_q[(s > 0) ? s - 1 : 0];
            end
        end
    end

    assign out_valid = v_q[LAT-1];
    assign out_data  = d_q[LAT-1];
endmodule

// File: rtl/cfg_header_regs.sv
// cfg_header_regs: type-0 configuration header register file. Decodes
// each access, applies per-register write rules, assembles little-endian
// read data and returns a response after RSP_LAT cycles. Assumes one
// access per cycle with data aligned to the least significant bit.
module cfg_header_regs
    import cfg_pkg::*;
#(
    parameter logic [15:0] VENDOR_ID     = 16'h1234,
    parameter logic [15:0] DEVICE_ID     = 16'h0001,
    parameter logic [7:0]  REVISION_ID   = 8'h01,
    parameter logic [23:0] CLASS_ID      = 24'h020000,
    parameter logic [15:0] SUBSYS_VENDOR = 16'h0000,
    parameter logic [15:0] SUBSYS_ID     = 16'h0000,
    parameter logic [15:0] COMMAND_INIT  = 16'h0000,
    parameter logic [15:0] STATUS_INIT   = 16'h0000,
    parameter logic [7:0]  INT_LINE_INIT = 8'h00,
    parameter logic [7:0]  INT_PIN       = 8'h01,
    parameter logic [7:0]  MIN_GNT       = 8'h00,
    parameter logic [7:0]  MAX_LAT       = 8'h00,
    parameter logic [31:0] ROM_INIT      = 32'h0,
    parameter logic [NUM_BARS*32-1:0] BAR_INIT   = '0,
    parameter logic [NUM_BARS*32-1:0] BAR_SIZE   = {NUM_BARS{32'h0000_1000}},
    parameter logic [NUM_BARS-1:0]    BAR_LEGACY = '0,
    parameter int RSP_LAT = 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    input  logic                     req_write,
    input  logic [7:0]               req_offset,
    input  logic [2:0]               req_size,
    input  logic [31:0]              req_wdata,
    output logic                     rsp_valid,
    output logic [31:0]              rsp_rdata,
    output logic                     rsp_err,
    output logic [NUM_BARS*32-1:0]   bar_base,
    output logic [NUM_BARS*32-1:0]   bar_size,
    output logic                     range_chg
);
    logic [15:0] cmd_q, sts_q;
    logic [7:0]  cls_q, lat_q, intl_q;
    logic [31:0] rom_q;
    logic        sz1, sz2, sz4, align_ok, byte_ok, half_ok, acc_err, do_wr;
    logic [31:0] words [WORDS];
    logic [31:0] bar_rd [NUM_BARS];
    logic [31:0] rd_shift, rd_data;
    logic [NUM_BARS-1:0] bar_wr, reloc;

    // Access classification and error decode.
    always_comb begin
        sz1      = (req_size == 3'd1);
        sz2      = (req_size == 3'd2);
        sz4      = (req_size == 3'd4);
        align_ok = sz1 || (sz2 && !req_offset[0]) || (sz4 && req_offset[1:0] == 2'b00);
        byte_ok  = (req_offset == OFF_CLS) || (req_offset == OFF_LAT) ||
                   (req_offset == OFF_INTL) ||
                   (req_offset >= OFF_REV && req_offset <= OFF_REV + 8'd3) ||
                   (req_offset >= OFF_INTP && req_offset < HDR_END);
        half_ok  = (req_offset == OFF_CMD) || (req_offset == OFF_STS) ||
                   (req_offset == OFF_CLS);
        acc_err  = (req_offset >= HDR_END) || !align_ok ||
                   (req_write && sz1 && !byte_ok) ||
                   (req_write && sz2 && !half_ok);
        do_wr    = req_valid && req_write && !acc_err;
    end

    // Scalar header registers with per-size write rules.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q  <= COMMAND_INIT;
            sts_q  <= STATUS_INIT;
            cls_q  <= '0;
            lat_q  <= '0;
            intl_q <= INT_LINE_INIT;
            rom_q  <= ROM_INIT;
        end else if (do_wr) begin
            if (sz1) begin
                if (req_offset == OFF_CLS)  cls_q  <= req_wdata[7:0];
                if (req_offset == OFF_LAT)  lat_q  <= req_wdata[7:0];
                if (req_offset == OFF_INTL) intl_q <= req_wdata[7:0];
            end else if (sz2) begin
                if (req_offset == OFF_CMD) cmd_q <= req_wdata[15:0];
                if (req_offset == OFF_STS) sts_q <= req_wdata[15:0];
                if (req_offset == OFF_CLS) cls_q <= req_wdata[7:0];
            end else begin
                if (req_offset == OFF_CMD) cmd_q <= req_wdata[15:0];
                if (req_offset == OFF_ROM)
                    rom_q <= (req_wdata == ROM_PROBE) ? ALL_ONES : req_wdata;
            end
        end
    end

    for (genvar i = 0; i < NUM_BARS; i++) begin : g_bar
        assign bar_wr[i] = do_wr && sz4 && (req_offset == OFF_BAR0 + 8'(4 * i));
        cfg_bar_slot #(
            .INIT   (BAR_INIT[32*i +: 32]),
            .SIZE   (BAR_SIZE[32*i +: 32]),
            .LEGACY (BAR_LEGACY[i])
        ) u_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (bar_wr[i]),
            .wdata   (req_wdata),
            .rd_val  (bar_rd[i]),
            .base_o  (bar_base[32*i +: 32]),
            .reloc_o (reloc[i])
        );
        assign bar_size[32*i +: 32] = BAR_SIZE[32*i +: 32];
    end

    assign range_chg = |reloc;

    // Dword image of the header for the read mux.
    always_comb begin
        for (int w = 0; w < WORDS; w++) words[w] = '0;
        words[0]  = {DEVICE_ID, VENDOR_ID};
        words[1]  = {sts_q, cmd_q};
        words[2]  = {CLASS_ID, REVISION_ID};
        words[3]  = {16'h0000, lat_q, cls_q};
        for (int b = 0; b < NUM_BARS; b++) words[4 + b] = bar_rd[b];
        words[11] = {SUBSYS_ID, SUBSYS_VENDOR};
        words[12] = rom_q;
        words[15] = {MAX_LAT, MIN_GNT, INT_PIN, intl_q};
    end

    // Byte-lane alignment and size masking of read data.
    always_comb begin
        rd_shift = words[req_offset[5:2]] >> {req_offset[1:0], 3'b000};
        if (acc_err)  rd_data = '0;
        else if (sz1) rd_data = {24'h0, rd_shift[7:0]};
        else if (sz2) rd_data = {16'h0, rd_shift[15:0]};
        else          rd_data = rd_shift;
    end

    cfg_rsp_pipe #(.LAT(RSP_LAT), .W(33)) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (req_valid),
        .in_data   ({acc_err, rd_data}),
        .out_valid (rsp_valid),
        .out_data  ({rsp_err, rsp_rdata})
    );

    // R8: an error response never carries data
    assert_err_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 32'd0));

    // R6: the ROM probe value is replaced by all ones
    assert_rom_probe_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (do_wr && sz4 && req_offset == OFF_ROM && req_wdata == ROM_PROBE)
        |=> (rom_q == ALL_ONES));
endmodule

// File: tb/cfg_header_regs_tb.sv
module cfg_header_regs_tb;
    localparam int LAT = 2;
    localparam logic [191:0] B_INIT = {32'h0, 32'h0000_0008, 32'h0, 32'h0000_03F9,
                                       32'h0000_0001, 32'h0};
    localparam logic [191:0] B_SIZE = {32'h0000_1000, 32'h0010_0000, 32'h0,
                                       32'h0000_0008, 32'h0000_0100, 32'h0000_1000};

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, req_write = 0;
    logic [7:0] req_offset = 0;
    logic [2:0] req_size = 0;
    logic [31:0] req_wdata = 0;
    logic rsp_valid, rsp_err, range_chg;
    logic [31:0] rsp_rdata;
    logic [191:0] bar_base, bar_size;
    int n_chk = 0, n_bad = 0;
    bit done = 0;
    logic [31:0] r_data;
    logic r_err, r_rc, r_rc2;

    always #2.5 clk = ~clk;

    cfg_header_regs #(
        .VENDOR_ID(16'hC0DE), .DEVICE_ID(16'h0B5E), .REVISION_ID(8'h07),
        .CLASS_ID(24'h020000), .SUBSYS_VENDOR(16'h5A5A), .SUBSYS_ID(16'hA5A5),
        .STATUS_INIT(16'h0010), .INT_LINE_INIT(8'h0B), .INT_PIN(8'h01),
        .MIN_GNT(8'h10), .MAX_LAT(8'h20),
        .BAR_INIT(B_INIT), .BAR_SIZE(B_SIZE), .BAR_LEGACY(6'b000100), .RSP_LAT(LAT)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
        .bar_base(bar_base), .bar_size(bar_size), .range_chg(range_chg)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    // One access: drive at a falling edge, sample the strobe and the response.
    task automatic access(input logic [7:0] off, input logic [2:0] sz,
                          input logic wr, input logic [31:0] wd);
        @(negedge clk);
        req_valid = 1; req_write = wr; req_offset = off; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 0; req_write = 0;
        r_rc = range_chg;
        for (int k = 1; k < LAT; k++) @(negedge clk);
        r_rc2 = range_chg;
        chk("R11 rsp_valid", {31'h0, rsp_valid}, 32'h1);
        r_data = rsp_rdata;
        r_err = rsp_err;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] off, input logic [2:0] sz,
                          input logic [31:0] exp);
        access(off, sz, 0, 0);
        chk(req, r_data, exp);
        chk({req, " err"}, {31'h0, r_err}, 32'h0);
    endtask

    task automatic wr_do(input logic [7:0] off, input logic [2:0] sz, input logic [31:0] wd,
                         input logic exp_err);
        access(off, sz, 1, wd);
        chk("R8 write err flag", {31'h0, r_err}, {31'h0, exp_err});
    endtask

    task automatic t_reset;
        chk("R1 rsp_valid reset", {31'h0, rsp_valid}, 0);
        chk("R1 range_chg reset", {31'h0, range_chg}, 0);
        chk("R1 base0 reset", bar_base[31:0], 0);
        chk("R1 base2 legacy reset", bar_base[95:64], 32'h3F9);
        rd_chk("R1 ids", 8'h00, 4, 32'h0B5EC0DE);
        rd_chk("R1 class/rev", 8'h08, 4, 32'h02000007);
        rd_chk("R1 tail", 8'h3C, 4, 32'h2010010B);
        rd_chk("R1 device half", 8'h02, 2, 32'h0B5E);
        rd_chk("R1 int pin byte", 8'h3D, 1, 32'h01);
        rd_chk("R1 subsystem", 8'h2C, 4, 32'hA5A55A5A);
        rd_chk("R1 cache/lat reset", 8'h0C, 4, 32'h0);
    endtask

    task automatic t_latency;
        @(negedge clk);
        req_valid = 1; req_offset = 8'h00; req_size = 4;
        @(negedge clk);
        req_valid = 0;
        chk("R11 not early", {31'h0, rsp_valid}, 0);
        @(negedge clk);
        chk("R11 on time", {31'h0, rsp_valid}, 1);
        chk("R11 data", rsp_rdata, 32'h0B5EC0DE);
        @(negedge clk);
        chk("R11 one cycle", {31'h0, rsp_valid}, 0);
    endtask

    task automatic t_probe;
        wr_do(8'h10, 4, 32'hFFFFFFFF, 0);
        chk("R2 probe no strobe", {31'h0, r_rc}, 0);
        rd_chk("R2 bar0 mask", 8'h10, 4, 32'hFFFFF000);
        wr_do(8'h14, 4, 32'hFFFFFFFF, 0);
        rd_chk("R2 bar1 io mask", 8'h14, 4, 32'hFFFFFF01);
        wr_do(8'h20, 4, 32'hFFFFFFFF, 0);
        rd_chk("R2 bar4 type kept", 8'h20, 4, 32'hFFF00008);
        wr_do(8'h1C, 4, 32'hFFFFFFFF, 0);
        rd_chk("R2 size zero", 8'h1C, 4, 32'h0);
        chk("R2 base0 untouched", bar_base[31:0], 0);
    endtask

    task automatic t_reloc;
        wr_do(8'h10, 4, 32'h8000000F, 0);
        chk("R4 strobe", {31'h0, r_rc}, 1);
        chk("R4 strobe one cycle", {31'h0, r_rc2}, 0);
        chk("R4 base0", bar_base[31:0], 32'h80000000);
        rd_chk("R3 bar0 mem bits", 8'h10, 4, 32'h80000000);
        wr_do(8'h14, 4, 32'h0000C0FF, 0);
        chk("R4 base1", bar_base[63:32], 32'h0000C0FC);
        rd_chk("R3 bar1 io bits", 8'h14, 4, 32'h0000C0FD);
        wr_do(8'h20, 4, 32'hE0000007, 0);
        chk("R4 base4", bar_base[159:128], 32'hE0000000);
        rd_chk("R3 bar4 prefetch bit", 8'h20, 4, 32'hE0000008);
        wr_do(8'h10, 4, 32'h0000000F, 0);
        chk("R4 zero addr no strobe", {31'h0, r_rc}, 0);
        chk("R4 zero addr base kept", bar_base[31:0], 32'h80000000);
        rd_chk("R3 zero addr stored", 8'h10, 4, 32'h0);
    endtask

    task automatic t_legacy;
        wr_do(8'h18, 4, 32'h12345678, 0);
        chk("R5 no strobe", {31'h0, r_rc}, 0);
        rd_chk("R5 reads zero", 8'h18, 4, 32'h0);
        wr_do(8'h18, 4, 32'hFFFFFFFF, 0);
        rd_chk("R5 probe reads zero", 8'h18, 4, 32'h0);
        chk("R5 base fixed", bar_base[95:64], 32'h3F9);
    endtask

    task automatic t_rom;
        wr_do(8'h30, 4, 32'hFFFFFFFE, 0);
        rd_chk("R6 probe", 8'h30, 4, 32'hFFFFFFFF);
        wr_do(8'h30, 4, 32'h00ABC001, 0);
        rd_chk("R6 plain", 8'h30, 4, 32'h00ABC001);
    endtask

    task automatic t_byte;
        wr_do(8'h0C, 1, 32'h40, 0);
        wr_do(8'h0D, 1, 32'h80, 0);
        rd_chk("R7 cache/lat", 8'h0C, 4, 32'h00008040);
        wr_do(8'h3C, 1, 32'h05, 0);
        rd_chk("R7 int line", 8'h3C, 1, 32'h05);
        wr_do(8'h3D, 1, 32'hFF, 0);
        rd_chk("R7 int pin ignored", 8'h3D, 1, 32'h01);
        wr_do(8'h3F, 1, 32'hFF, 0);
        wr_do(8'h08, 1, 32'hFF, 0);
        wr_do(8'h0A, 1, 32'hFF, 0);
        rd_chk("R7 rev/class ignored", 8'h08, 4, 32'h02000007);
        rd_chk("R7 max lat ignored", 8'h3C, 4, 32'h20100105);
        wr_do(8'h00, 1, 32'hFF, 1);
        rd_chk("R7 vendor unchanged", 8'h00, 4, 32'h0B5EC0DE);
    endtask

    task automatic t_half;
        wr_do(8'h04, 2, 32'hFFFF0147, 0);
        rd_chk("R10 command", 8'h04, 4, 32'h00100147);
        wr_do(8'h06, 2, 32'h0000BEEF, 0);
        rd_chk("R10 status", 8'h04, 4, 32'hBEEF0147);
        rd_chk("R10 status half", 8'h06, 2, 32'hBEEF);
        wr_do(8'h0C, 2, 32'h7720, 0);
        rd_chk("R10 cache only", 8'h0C, 4, 32'h00008020);
        wr_do(8'h02, 2, 32'h1111, 1);
        rd_chk("R10 bad half no effect", 8'h00, 4, 32'h0B5EC0DE);
    endtask

    task automatic t_word;
        wr_do(8'h04, 4, 32'hDEAD0006, 0);
        rd_chk("R9 command only", 8'h04, 4, 32'hBEEF0006);
        wr_do(8'h00, 4, 32'hFFFFFFFF, 0);
        rd_chk("R9 ids discarded", 8'h00, 4, 32'h0B5EC0DE);
        wr_do(8'h3C, 4, 32'h00000000, 0);
        rd_chk("R9 tail discarded", 8'h3C, 4, 32'h20100105);
    endtask

    task automatic t_err;
        access(8'h40, 4, 0, 0);
        chk("R8 high offset err", {31'h0, r_err}, 1);
        chk("R8 high offset data", r_data, 0);
        access(8'h02, 4, 0, 0);
        chk("R8 misaligned word", {31'h0, r_err}, 1);
        access(8'h01, 2, 0, 0);
        chk("R8 odd half", {31'h0, r_err}, 1);
        chk("R8 odd half data", r_data, 0);
        access(8'h00, 3, 0, 0);
        chk("R8 bad size", {31'h0, r_err}, 1);
        wr_do(8'h44, 4, 32'h12345678, 1);
        wr_do(8'h32, 4, 32'h12345678, 1);
        rd_chk("R8 rom unchanged", 8'h30, 4, 32'h00ABC001);
    endtask

    task automatic t_size;
        chk("R12 size0", bar_size[31:0], 32'h1000);
        chk("R12 size1", bar_size[63:32], 32'h100);
        chk("R12 size3", bar_size[127:96], 32'h0);
        chk("R12 size4", bar_size[159:128], 32'h100000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_latency;
        t_probe;
        t_reloc;
        t_legacy;
        t_rom;
        t_byte;
        t_half;
        t_word;
        t_err;
        t_size;
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule